// File: doc/BRIEF.md
# I2C High-Speed Mode Entry Detector

This block watches the sampled clock and data lines of an I2C bus from the target side. It keeps track of whether the bus is running at standard/fast speed or in high-speed mode. It finds START, repeated START and STOP conditions and collects the first byte after every START. If that byte is the high-speed master code, the block leaves the acknowledge slot released, as every target must. It arms itself and enters high-speed mode at the next repeated START. It stays in high-speed mode across any number of further repeated STARTs, and a STOP returns it to standard/fast mode.

If the first byte is not a master code, the block reads it as a 7-bit address followed by a read/write bit. It compares the address with `dev_addr`. On a match it pulls SDA low for the ninth clock and gives a one-cycle strobe that carries the read/write bit. All traffic after that acknowledge is ignored until the next START or STOP. The inputs must already be synchronised to `clk`, and `clk` must run well above the bus bit rate.

Top module: `hs_mode_tracker`

## Requirements
- R1: After reset, `hs_mode`, `sda_pull` and `addr_stb` are 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Data bits are taken on SCL rising edges, MSB first. A byte sent without a preceding START gets no acknowledge and no strobe.
- R3: Outside high-speed mode, a first byte whose top five bits are 00001 (low three bits any) is the master code. Its ninth clock sees SDA released and no strobe is given, even if `dev_addr` equals its upper seven bits.
- R4: The repeated START that follows a master code sets `hs_mode` to 1. The address byte after that START is acknowledged when it matches.
- R5: Once set, `hs_mode` stays 1 through further repeated STARTs, address bytes and data bytes until a STOP.
- R6: A STOP clears `hs_mode` and any pending master code. A master code followed by STOP and then a plain START does not enter high-speed mode.
- R7: A first byte whose upper seven bits equal `dev_addr` gives one `addr_stb` pulse with `addr_rw` equal to its eighth bit. `sda_pull` rises only while SCL is low after the eighth bit and is held through the ninth SCL high phase. It is released after the ninth falling edge.
- R8: A first byte whose upper seven bits differ from `dev_addr` (and that is not a master code) gives no strobe and no acknowledge.
- R9: In high-speed mode, a first byte with top bits 00001 is an ordinary address and is acknowledged when it matches `dev_addr`.
- R10: Bytes after the acknowledge slot are ignored until the next START or STOP, even when a byte equals the matching address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Synchronised bus clock sample |
| sda | input | 1 | Synchronised bus data sample |
| dev_addr | input | AW | Own 7-bit target address |
| hs_mode | output | 1 | 1 while the bus is in high-speed mode |
| sda_pull | output | 1 | 1 to pull SDA low for the acknowledge |
| addr_stb | output | 1 | One-cycle pulse on a matching address byte |
| addr_rw | output | 1 | Read/write bit of the last matching address byte |

## Verification
All 256 first-byte values after a plain START are tried against a fixed own address. This separates the eight master-code values, the two values that match the address (one read, one write) and every mismatch. Each master code is followed by a repeated START and an address byte, to show that high-speed mode is entered and that a STOP leaves it. Directed sequences cover a master code cut short by a STOP, chained repeated STARTs, a reserved-looking address while in high-speed mode, data bytes that equal the address, and a byte clocked without a START.

// File: rtl/hs_mode_tracker.sv
module hs_mode_tracker #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl,
  input  logic          sda,
  input  logic [AW-1:0] dev_addr,
  output logic          hs_mode,
  output logic          sda_pull,
  output logic          addr_stb,
  output logic          addr_rw
);
  localparam int BW = AW + 1;
  localparam int CW = $clog2(BW);
  localparam logic [4:0] MC_TOP = 5'b00001;

  typedef enum logic [1:0] {S_IDLE, S_BYTE, S_ACK, S_SKIP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] sr;
  logic          scl_q, sda_q, arm_q, match_q, fell_q;

  wire rise  = scl & ~scl_q;
  wire fall  = ~scl & scl_q;
  wire start = scl & scl_q & sda_q & ~sda;
  wire stop  = scl & scl_q & ~sda_q & sda;
  wire last  = (cnt == CW'(BW - 1));
  wire is_mc = ~hs_mode & (sr[AW-1 -: 5] == MC_TOP);
  wire hit   = (sr == dev_addr);

  assign sda_pull = (st == S_ACK) & match_q & fell_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sr <= '0;
      scl_q <= 1'b1; sda_q <= 1'b1;
      hs_mode <= 1'b0; arm_q <= 1'b0; match_q <= 1'b0; fell_q <= 1'b0;
      addr_stb <= 1'b0; addr_rw <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      addr_stb <= 1'b0;
      if (stop) begin
        st <= S_IDLE; hs_mode <= 1'b0; arm_q <= 1'b0;
        match_q <= 1'b0; fell_q <= 1'b0;
      end else if (start) begin
        st <= S_BYTE; cnt <= '0;
        if (arm_q) hs_mode <= 1'b1;
        arm_q <= 1'b0; match_q <= 1'b0; fell_q <= 1'b0;
      end else begin
        case (st)
          S_BYTE: if (rise) begin
            cnt <= cnt + 1'b1;
            if (!last) sr <= {sr[AW-2:0], sda};
            else begin
              st <= S_ACK;
              if (is_mc) arm_q <= 1'b1;
              else if (hit) begin
                match_q <= 1'b1; addr_stb <= 1'b1; addr_rw <= sda;
              end
            end
          end
          S_ACK: if (fall) begin
            if (!fell_q) fell_q <= 1'b1;
            else begin
              st <= S_SKIP; fell_q <= 1'b0; match_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_mc_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> !sda_pull);
  p_hs_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> $past(start));
  p_hs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_mode && !stop) |=> hs_mode);
  p_stop_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!hs_mode && !arm_q));
  p_pull_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl);
  p_stb_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> !addr_stb);
endmodule

// File: tb/sim_hs_mode_tracker.sv
`timescale 1ns/1ps
module sim_hs_mode_tracker;
  localparam logic [6:0] DEV = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0, scl_b = 1'b1, sda_m = 1'b1;
  logic [6:0] dev_addr = DEV;
  logic hs_mode, sda_pull, addr_stb, addr_rw;
  wire sda_line = sda_m & ~sda_pull;
  int checks = 0, errors = 0, stb_n = 0;
  logic rw_seen = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hs_mode_tracker u0 (.clk(clk), .rst_n(rst_n), .scl(scl_b), .sda(sda_line),
    .dev_addr(dev_addr), .hs_mode(hs_mode), .sda_pull(sda_pull),
    .addr_stb(addr_stb), .addr_rw(addr_rw));

  always @(negedge clk) if (addr_stb) begin stb_n++; rw_seen = addr_rw; end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_start();
    if (!scl_b) begin sda_m = 1'b1; tick(2); scl_b = 1'b1; tick(4); end
    sda_m = 1'b0; tick(4); scl_b = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(2); scl_b = 1'b1; tick(4); sda_m = 1'b1; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(2); scl_b = 1'b1; tick(4); scl_b = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(2); scl_b = 1'b1; tick(2);
    ack = ~sda_line; tick(2); scl_b = 1'b0; tick(2);
  endtask

  initial begin
    tick(200_000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic ack;
    int s0;
    tick(3);
    check("R1 hs_mode", int'(hs_mode), 0);
    check("R1 sda_pull", int'(sda_pull), 0);
    check("R1 addr_stb", int'(addr_stb), 0);
    rst_n = 1'b1; tick(3);

    for (int v = 0; v < 256; v++) begin
      logic [7:0] b = 8'(v);
      bit mc = (b[7:3] == 5'b00001);
      bit ex = !mc && (b[7:1] == DEV);
      s0 = stb_n;
      bus_start();
      send_byte(b, ack);
      check(mc ? "R3 mc nack" : (ex ? "R7 ack" : "R8 nack"), int'(ack), int'(ex));
      check(ex ? "R7 strobe" : "R8 no strobe", stb_n - s0, int'(ex));
      check("R7 released after ninth", int'(sda_pull), 0);
      if (ex) check("R7 rw", int'(rw_seen), int'(b[0]));
      if (mc) begin
        bus_start();
        check("R4 hs entry", int'(hs_mode), 1);
        send_byte({DEV, 1'b1}, ack);
        check("R4 hs addr ack", int'(ack), 1);
        check("R4 hs rw", int'(rw_seen), 1);
      end
      bus_stop();
      check("R6 stop clears", int'(hs_mode), 0);
    end

    // R2: byte without a START
    s0 = stb_n;
    scl_b = 1'b0; tick(2); sda_m = 1'b0; tick(2);
    send_byte({DEV, 1'b0}, ack);
    check("R2 no start no ack", int'(ack), 0);
    check("R2 no start no strobe", stb_n - s0, 0);
    bus_stop();

    // R5: chained repeated STARTs
    bus_start(); send_byte(8'h0B, ack);
    bus_start(); send_byte({DEV, 1'b0}, ack);
    check("R5 ack", int'(ack), 1);
    send_byte(8'h33, ack);
    check("R5 hold after data", int'(hs_mode), 1);
    bus_start(); send_byte(8'hC4, ack);
    check("R5 mismatch in hs", int'(ack), 0);
    check("R5 hold after Sr", int'(hs_mode), 1);
    bus_start(); send_byte({DEV, 1'b1}, ack);
    check("R5 ack again", int'(ack), 1);
    check("R5 hold", int'(hs_mode), 1);
    bus_stop();
    check("R5 stop ends", int'(hs_mode), 0);

    // R6: master code aborted by STOP
    bus_start(); send_byte(8'h0E, ack); bus_stop();
    bus_start();
    check("R6 no hs after stop", int'(hs_mode), 0);
    send_byte({DEV, 1'b0}, ack);
    check("R6 plain addr ack", int'(ack), 1);
    check("R6 still fast", int'(hs_mode), 0);
    bus_stop();

    // R3 priority and R9 in high-speed mode
    dev_addr = 7'b0000101; tick(2);
    s0 = stb_n;
    bus_start(); send_byte(8'h0A, ack);
    check("R3 mc beats address", int'(ack), 0);
    check("R3 no strobe", stb_n - s0, 0);
    bus_start();
    check("R9 hs", int'(hs_mode), 1);
    send_byte(8'h0A, ack);
    check("R9 ack in hs", int'(ack), 1);
    check("R9 strobe", stb_n - s0, 1);
    bus_stop();
    dev_addr = DEV; tick(2);

    // R10: data equal to address ignored
    bus_start(); send_byte({DEV, 1'b0}, ack);
    s0 = stb_n;
    send_byte({DEV, 1'b0}, ack);
    check("R10 data nack", int'(ack), 0);
    check("R10 no strobe", stb_n - s0, 0);
    send_byte(8'h0F, ack);
    check("R10 no hs arm", int'(ack), 0);
    bus_stop();
    bus_start();
    check("R10 no hs", int'(hs_mode), 0);
    bus_stop();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule